// File: doc/BRIEF.md
# Broadcast Stream Receiver Register File

This block is the processor-facing register set for a receiver that takes in two separate packet streams. Each stream has a window of six byte registers: a 14-bit channel number held in a low byte and a 6-bit high byte, a read-only queued-packet count, a prefix latch, a data latch and a sticky status byte. The upstream receiver announces a newly opened stream with a one-cycle load pulse that carries the number of queued packets. It then offers payload bytes, one at a time, on a valid/ready byte port. A packet is 22 bytes long, so the upstream side offers 22 bytes for each announced packet; the register file itself only counts packets and hands out whatever bytes are offered.

Software starts a stream by writing nonzero values to its prefix-latch and data-latch addresses, which enables those latches. Each read of the prefix latch takes one packet off the queue and reports whether it is the first or the last packet. Each read of the data latch hands out the next payload byte. The flags returned by every prefix read are ORed into the status byte, and reading the status byte clears it.

Selecting channel number zero turns the stream into a clock channel. Its data latch then steps through a 23-byte time record built from an external time input, and the record index is shared by both streams. A small group of miscellaneous registers sits just above the two stream windows. Any address that is not decoded returns the open-bus value.

Top module: `bcast_rx_regs`

## Requirements
- R1: Stream register offsets from the stream base (0x2188 for stream 0, 0x218E for stream 1) are: 0 channel low byte, 1 channel high byte, 2 packet count, 3 prefix latch, 4 data latch, 5 status. The channel low byte stores all 8 written bits. The channel high byte stores only bits 5:0 of a write and reads back with bits 7:6 zero.
- R2: A write to offset 3 or offset 4 enables that latch if the data is nonzero and disables it if the data is zero. A read of a disabled latch returns 0x00 and changes no state. The count reads 0x00 unless both latches of the stream are enabled.
- R3: With both latches enabled, the count reads 0x01 when the channel number is zero. Otherwise it reads the number of queued packets, saturated at 0x7F, once a load pulse has been seen, and it reads 0x00 before any load pulse.
- R4: On a nonzero channel, after a load pulse, a prefix read removes one packet from the queue (the queue stays at zero if already empty) and returns a byte with bit 4 set on the first read after the load pulse and bit 7 set when the queue is zero after the read. All other bits are zero. A load pulse sets the queue to its packet-count input and arms the first flag.
- R5: Every value returned by an enabled prefix read is ORed into the status register. A status read returns the accumulated value and leaves it at 0x00.
- R6: On a nonzero channel, after a load pulse, an enabled data-latch read asserts the stream's byte-ready output. It returns the offered byte and consumes it when byte-valid is high, and returns 0xFF when no byte is offered.
- R7: On channel zero, an enabled prefix read returns 0x90 and an enabled data-latch read returns the time-record byte at the shared index, then advances the index from 0 up to 22 and back to 0. Record bytes 4, 5 and 6 are 0x10, 0x01 and 0x01. Bytes 10 to 17 are the time-input bytes 0 to 7 (seconds, minutes, hours, weekday, day, month, year low, year high, byte 0 in bits 7:0). All other record bytes are 0x00.
- R8: A write to a stream's data-latch address while that stream's channel is zero resets the shared index to 0 and captures the time input. The time input has no effect on the record at any other moment.
- R9: 0x2194 is a 4-bit read/write register that resets to 0. 0x2197 is an 8-bit read/write register that resets to 0x80. 0x2196 always reads 0x10. 0x2195, 0x2198 and 0x2199 read 0x00.
- R10: Reads of addresses outside 0x2188–0x2199 return the open-bus input. Writes to the count, status, 0x2195, 0x2196, 0x2198 and 0x2199 addresses have no effect.
- R11: The two streams keep independent state: an access to one stream's window never changes the other stream's registers.
- R12: The read-data output is registered. It takes the read value on the clock edge where the read strobe is high, holds it until the next read, and is 0x00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| open_bus | input | 8 | Value returned for undecoded reads |
| rd_data | output | 8 | Registered read data |
| time_in | input | 64 | Time bytes: sec, min, hour, weekday, day, month, year lo, year hi (byte 0 in bits 7:0) |
| s_load | input | 2 | Per-stream pulse announcing a newly opened stream |
| s_pkts | input | 32 | Per-stream queued-packet count, 16 bits each, sampled with s_load |
| s_byte_valid | input | 2 | Per-stream payload byte offered |
| s_byte | input | 16 | Per-stream payload byte, 8 bits each |
| s_byte_ready | output | 2 | Per-stream payload byte taken this cycle |

## Verification
The packet path is run with a large queue, which shows the 0x7F saturation and that the first flag appears only once. A two-packet queue shows the last flag and how the status byte accumulates the flags. A one-packet queue on the second stream shows both flags in one read and shows that the other stream is left untouched. Payload reads are made with the byte queue first non-empty and then empty, which separates a consumed byte from the 0xFF filler. On the clock channel, the record is read all the way past its wrap point, and the time input is changed before and after an index restart, which shows that it is sampled only at the restart. Latch-disabled reads, undecoded addresses and writes to read-only locations are checked against the open-bus value and the unchanged register contents.

// File: rtl/bcast_pkg.sv
package bcast_pkg;
    localparam logic [15:0] WIN_BASE    = 16'h2188;
    localparam int          WIN_REGS    = 6;
    localparam int          REC_LAST    = 22;
    localparam int          REC_TIME_LO = 10;
    localparam int          REC_IDX_W   = 5;

    typedef enum logic [2:0] {
        OFF_CH_LO  = 3'd0,
        OFF_CH_HI  = 3'd1,
        OFF_COUNT  = 3'd2,
        OFF_PREFIX = 3'd3,
        OFF_DATA   = 3'd4,
        OFF_STAT   = 3'd5
    } reg_off_e;

    typedef enum logic [2:0] {
        MISC_LED   = 3'd0,
        MISC_RSVD  = 3'd1,
        MISC_STAT  = 3'd2,
        MISC_SOUND = 3'd3
    } misc_off_e;

    localparam logic [7:0] PFX_FIRST  = 8'h10;
    localparam logic [7:0] PFX_LAST   = 8'h80;
    localparam logic [7:0] PFX_CLOCK  = 8'h90;
    localparam logic [7:0] DATA_EMPTY = 8'hFF;
    localparam logic [7:0] SAT_COUNT  = 8'h7F;
    localparam logic [7:0] STAT_CONST = 8'h10;
    localparam logic [7:0] SOUND_RST  = 8'h80;
endpackage

// File: rtl/bcast_time_rec.sv
module bcast_time_rec
    import bcast_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        adv,
    input  logic        restart,
    input  logic [63:0] time_in,
    output logic [7:0]  rec_byte
);
    typedef struct packed {
        logic [REC_IDX_W-1:0] idx;
        logic [63:0]          snap;
    } rec_st;

    rec_st r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (restart) begin
            r_d.idx  = '0;
            r_d.snap = time_in;
        end else if (adv) begin
            r_d.idx = (r_q.idx == REC_IDX_W'(REC_LAST)) ? '0 : r_q.idx + 1'b1;
        end
    end

    always_comb begin
        rec_byte = 8'h00;
        case (r_q.idx)
            REC_IDX_W'(4):           rec_byte = 8'h10;
            REC_IDX_W'(5),
            REC_IDX_W'(6):           rec_byte = 8'h01;
            default: begin
                if (r_q.idx >= REC_IDX_W'(REC_TIME_LO) &&
                    r_q.idx <  REC_IDX_W'(REC_TIME_LO + 8))
                    rec_byte = r_q.snap[8*(r_q.idx - REC_IDX_W'(REC_TIME_LO)) +: 8];
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R7: index stays within the 23-byte record
    assert_index_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.idx <= REC_IDX_W'(REC_LAST));

    // R8: restart puts the index back to zero
    assert_restart_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> r_q.idx == '0);
endmodule

// File: rtl/bcast_stream.sv
module bcast_stream
    import bcast_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic [2:0]       off,
    input  logic             rd,
    input  logic             wr,
    input  logic [7:0]       wdata,
    input  logic             load,
    input  logic [CNT_W-1:0] load_pkts,
    input  logic             byte_valid,
    input  logic [7:0]       byte_in,
    input  logic [7:0]       rec_byte,
    output logic             byte_ready,
    output logic [7:0]       rd_val,
    output logic             rec_adv,
    output logic             rec_restart
);
    localparam logic [CNT_W-1:0] SAT_Q = CNT_W'(SAT_COUNT);

    typedef struct packed {
        logic [7:0]       ch_lo;
        logic [5:0]       ch_hi;
        logic             pf_en;
        logic             dt_en;
        logic             loaded;
        logic             first;
        logic [CNT_W-1:0] queue;
        logic [7:0]       pf_val;
        logic [7:0]       dt_val;
        logic [7:0]       stat;
    } strm_st;

    strm_st s_d, s_q;
    logic   chan_zero;
    logic   do_rd, do_wr;
    logic [7:0]       pv, dv;
    logic [CNT_W-1:0] qn;

    assign chan_zero = (s_q.ch_lo == 8'h00) && (s_q.ch_hi == 6'h00);
    assign do_rd     = sel && rd;
    assign do_wr     = sel && wr;

    always_comb begin
        s_d         = s_q;
        rd_val      = 8'h00;
        byte_ready  = 1'b0;
        rec_adv     = 1'b0;
        rec_restart = 1'b0;
        pv          = s_q.pf_val;
        dv          = s_q.dt_val;
        qn          = s_q.queue;

        if (do_rd) begin
            case (off)
                OFF_CH_LO: rd_val = s_q.ch_lo;
                OFF_CH_HI: rd_val = {2'b00, s_q.ch_hi};
                OFF_COUNT: begin
                    if (s_q.pf_en && s_q.dt_en) begin
                        if (chan_zero)
                            rd_val = 8'h01;
                        else if (s_q.loaded)
                            rd_val = (s_q.queue > SAT_Q) ? SAT_COUNT : 8'(s_q.queue);
                    end
                end
                OFF_PREFIX: begin
                    if (s_q.pf_en) begin
                        if (chan_zero) begin
                            pv = PFX_CLOCK;
                        end else if (s_q.loaded) begin
                            pv = 8'h00;
                            if (s_q.first) begin
                                pv          = pv | PFX_FIRST;
                                s_d.first   = 1'b0;
                            end
                            if (s_q.queue != '0) qn = s_q.queue - 1'b1;
                            s_d.queue = qn;
                            if (qn == '0) pv = pv | PFX_LAST;
                        end
                        s_d.pf_val = pv;
                        s_d.stat   = s_q.stat | pv;
                        rd_val     = pv;
                    end
                end
                OFF_DATA: begin
                    if (s_q.dt_en) begin
                        if (chan_zero) begin
                            dv      = rec_byte;
                            rec_adv = 1'b1;
                        end else if (s_q.loaded) begin
                            byte_ready = 1'b1;
                            dv         = byte_valid ? byte_in : DATA_EMPTY;
                        end
                        s_d.dt_val = dv;
                        rd_val     = dv;
                    end
                end
                OFF_STAT: begin
                    rd_val   = s_q.stat;
                    s_d.stat = 8'h00;
                end
                default: rd_val = 8'h00;
            endcase
        end

        if (do_wr) begin
            case (off)
                OFF_CH_LO:  s_d.ch_lo = wdata;
                OFF_CH_HI:  s_d.ch_hi = wdata[5:0];
                OFF_PREFIX: s_d.pf_en = |wdata;
                OFF_DATA: begin
                    s_d.dt_en   = |wdata;
                    rec_restart = chan_zero;
                end
                default: ;
            endcase
        end

        if (load) begin
            s_d.loaded = 1'b1;
            s_d.first  = 1'b1;
            s_d.queue  = load_pkts;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R3: the count never reads above the saturation value
    assert_count_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && off == OFF_COUNT) |-> rd_val <= SAT_COUNT);

    // R4: the first flag is gone after a counted prefix read
    assert_first_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && off == OFF_PREFIX && s_q.pf_en && !chan_zero && s_q.loaded && !load)
        |=> !s_q.first);

    // R5: a status read leaves the register clear
    assert_stat_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && off == OFF_STAT) |=> s_q.stat == 8'h00);

    // R6: a byte is only taken by a data-latch read
    assert_ready_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> (do_rd && off == OFF_DATA && s_q.dt_en));

    // R2: a disabled prefix latch returns zero
    assert_pf_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && off == OFF_PREFIX && !s_q.pf_en) |-> rd_val == 8'h00);
endmodule

// File: rtl/bcast_rx_regs.sv
module bcast_rx_regs
    import bcast_pkg::*;
#(
    parameter int NUM_STREAMS = 2,
    parameter int CNT_W       = 16,
    parameter int ADDR_W      = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         bus_rd,
    input  logic                         bus_wr,
    input  logic [7:0]                   bus_wdata,
    input  logic [7:0]                   open_bus,
    output logic [7:0]                   rd_data,
    input  logic [63:0]                  time_in,
    input  logic [NUM_STREAMS-1:0]       s_load,
    input  logic [NUM_STREAMS*CNT_W-1:0] s_pkts,
    input  logic [NUM_STREAMS-1:0]       s_byte_valid,
    input  logic [NUM_STREAMS*8-1:0]     s_byte,
    output logic [NUM_STREAMS-1:0]       s_byte_ready
);
    localparam int MISC_LO  = NUM_STREAMS * WIN_REGS;
    localparam int MISC_HI  = MISC_LO + WIN_REGS;

    typedef struct packed {
        logic [3:0] led;
        logic [7:0] sound;
        logic [7:0] rdata;
    } top_st;

    top_st t_d, t_q;

    logic [ADDR_W-1:0]      rel;
    logic                   above;
    logic                   misc_hit;
    logic [2:0]             misc_off;
    logic [NUM_STREAMS-1:0] sel;
    logic [NUM_STREAMS-1:0] adv_v, rst_v;
    logic [7:0]             val_v [NUM_STREAMS];
    logic [7:0]             rec_byte;
    logic [7:0]             strm_val;
    logic                   strm_hit;

    assign rel      = bus_addr - ADDR_W'(WIN_BASE);
    assign above    = bus_addr >= ADDR_W'(WIN_BASE);
    assign misc_hit = above && rel >= ADDR_W'(MISC_LO) && rel < ADDR_W'(MISC_HI);
    assign misc_off = 3'(rel - ADDR_W'(MISC_LO));

    for (genvar k = 0; k < NUM_STREAMS; k++) begin : g_strm
        logic [2:0] off_k;
        assign sel[k] = above && rel >= ADDR_W'(k * WIN_REGS)
                              && rel <  ADDR_W'((k + 1) * WIN_REGS);
        assign off_k  = 3'(rel - ADDR_W'(k * WIN_REGS));

        bcast_stream #(.CNT_W(CNT_W)) u_strm (
            .clk         (clk),
            .rst_n       (rst_n),
            .sel         (sel[k]),
            .off         (off_k),
            .rd          (bus_rd),
            .wr          (bus_wr),
            .wdata       (bus_wdata),
            .load        (s_load[k]),
            .load_pkts   (s_pkts[k*CNT_W +: CNT_W]),
            .byte_valid  (s_byte_valid[k]),
            .byte_in     (s_byte[k*8 +: 8]),
            .rec_byte    (rec_byte),
            .byte_ready  (s_byte_ready[k]),
            .rd_val      (val_v[k]),
            .rec_adv     (adv_v[k]),
            .rec_restart (rst_v[k])
        );
    end

    bcast_time_rec u_rec (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (|adv_v),
        .restart  (|rst_v),
        .time_in  (time_in),
        .rec_byte (rec_byte)
    );

    always_comb begin
        strm_val = 8'h00;
        for (int k = 0; k < NUM_STREAMS; k++) strm_val = strm_val | val_v[k];
    end

    assign strm_hit = |sel;

    always_comb begin
        t_d = t_q;
        if (bus_rd) begin
            if (strm_hit) begin
                t_d.rdata = strm_val;
            end else if (misc_hit) begin
                case (misc_off)
                    MISC_LED:   t_d.rdata = {4'h0, t_q.led};
                    MISC_STAT:  t_d.rdata = STAT_CONST;
                    MISC_SOUND: t_d.rdata = t_q.sound;
                    default:    t_d.rdata = 8'h00;
                endcase
            end else begin
                t_d.rdata = open_bus;
            end
        end
        if (bus_wr && misc_hit) begin
            case (misc_off)
                MISC_LED:   t_d.led   = bus_wdata[3:0];
                MISC_SOUND: t_d.sound = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q.led   <= 4'h0;
            t_q.sound <= SOUND_RST;
            t_q.rdata <= 8'h00;
        end else begin
            t_q <= t_d;
        end
    end

    assign rd_data = t_q.rdata;

    // R10: undecoded reads return the open-bus value
    assert_open_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !strm_hit && !misc_hit) |=> rd_data == $past(open_bus));

    // R12: read data holds between reads
    assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(rd_data));

    // R11: at most one stream window is selected
    assert_one_window_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));
endmodule

// File: tb/bcast_rx_regs_bench.sv
module bcast_rx_regs_bench;
    localparam int NS = 2;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic          bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    open_bus = 8'h5A;
    logic [7:0]    rd_data;
    logic [63:0]   time_in = '0;
    logic [NS-1:0] s_load = '0;
    logic [NS*CW-1:0] s_pkts = '0;
    logic [NS-1:0] s_byte_valid = '0;
    logic [NS*8-1:0] s_byte = '0;
    logic [NS-1:0] s_byte_ready;

    bcast_rx_regs u_bcast_rx_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .open_bus(open_bus),
        .rd_data(rd_data), .time_in(time_in), .s_load(s_load), .s_pkts(s_pkts),
        .s_byte_valid(s_byte_valid), .s_byte(s_byte), .s_byte_ready(s_byte_ready)
    );

    always #2 clk = ~clk;

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R12";
    bit    done = 1'b0;

    // ---------------- behavioural reference model ----------------
    int         m_lo[NS], m_hi[NS], m_q[NS], m_pv[NS], m_dv[NS], m_st[NS];
    bit         m_pf[NS], m_dt[NS], m_ld[NS], m_first[NS];
    int         m_idx;
    logic [63:0] m_snap;
    int         m_led, m_sound;
    logic [7:0] exp_rd;
    logic [7:0] bq0[$], bq1[$];

    function automatic logic [7:0] rec(int i);
        if (i == 4) return 8'h10;
        if (i == 5 || i == 6) return 8'h01;
        if (i >= 10 && i <= 17) return m_snap[(i-10)*8 +: 8];
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NS; k++) begin
                m_lo[k]=0; m_hi[k]=0; m_q[k]=0; m_pv[k]=0; m_dv[k]=0; m_st[k]=0;
                m_pf[k]=0; m_dt[k]=0; m_ld[k]=0; m_first[k]=0;
            end
            m_idx = 0; m_snap = '0; m_led = 0; m_sound = 8'h80; exp_rd = 8'h00;
        end else begin
            int a, k, o;
            bit z;
            a = int'(bus_addr);
            k = (a - 16'h2188) / 6;
            o = (a - 16'h2188) % 6;
            if (bus_rd) begin
                if (a >= 16'h2188 && a < 16'h2194) begin
                    z = (m_lo[k] == 0 && m_hi[k] == 0);
                    case (o)
                        0: exp_rd = 8'(m_lo[k]);
                        1: exp_rd = 8'(m_hi[k]);
                        2: exp_rd = !(m_pf[k] && m_dt[k]) ? 8'h00 : z ? 8'h01 :
                                    m_ld[k] ? 8'((m_q[k] > 127) ? 127 : m_q[k]) : 8'h00;
                        3: if (!m_pf[k]) exp_rd = 8'h00;
                           else begin
                               if (z) m_pv[k] = 'h90;
                               else if (m_ld[k]) begin
                                   m_pv[k] = 0;
                                   if (m_first[k]) begin m_pv[k] = 'h10; m_first[k] = 0; end
                                   if (m_q[k] > 0) m_q[k]--;
                                   if (m_q[k] == 0) m_pv[k] |= 'h80;
                               end
                               m_st[k] |= m_pv[k];
                               exp_rd = 8'(m_pv[k]);
                           end
                        4: if (!m_dt[k]) exp_rd = 8'h00;
                           else begin
                               if (z) begin
                                   m_dv[k] = rec(m_idx);
                                   m_idx = (m_idx == 22) ? 0 : m_idx + 1;
                               end else if (m_ld[k]) begin
                                   if (s_byte_valid[k]) begin
                                       m_dv[k] = s_byte[k*8 +: 8];
                                       if (k == 0) void'(bq0.pop_front());
                                       else        void'(bq1.pop_front());
                                   end else m_dv[k] = 'hFF;
                               end
                               exp_rd = 8'(m_dv[k]);
                           end
                        default: begin exp_rd = 8'(m_st[k]); m_st[k] = 0; end
                    endcase
                end else if (a >= 16'h2194 && a <= 16'h2199) begin
                    case (a)
                        16'h2194: exp_rd = 8'(m_led);
                        16'h2196: exp_rd = 8'h10;
                        16'h2197: exp_rd = 8'(m_sound);
                        default:  exp_rd = 8'h00;
                    endcase
                end else exp_rd = open_bus;
            end
            if (bus_wr) begin
                if (a >= 16'h2188 && a < 16'h2194) begin
                    z = (m_lo[k] == 0 && m_hi[k] == 0);
                    case (o)
                        0: m_lo[k] = int'(bus_wdata);
                        1: m_hi[k] = int'(bus_wdata) & 'h3F;
                        3: m_pf[k] = (bus_wdata != 0);
                        4: begin
                            m_dt[k] = (bus_wdata != 0);
                            if (z) begin m_idx = 0; m_snap = time_in; end
                        end
                        default: ;
                    endcase
                end else if (a == 16'h2194) m_led = int'(bus_wdata) & 'hF;
                else if (a == 16'h2197) m_sound = int'(bus_wdata);
            end
            for (int j = 0; j < NS; j++)
                if (s_load[j]) begin
                    m_ld[j] = 1; m_first[j] = 1; m_q[j] = int'(s_pkts[j*CW +: CW]);
                end
        end
    end

    // byte sources: drivers change only at the falling edge
    always @(negedge clk) begin
        s_byte_valid[0] <= (bq0.size() > 0);
        s_byte[7:0]     <= (bq0.size() > 0) ? bq0[0] : 8'h00;
        s_byte_valid[1] <= (bq1.size() > 0);
        s_byte[15:8]    <= (bq1.size() > 0) ? bq1[0] : 8'h00;
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_cmp++;
            if (rd_data !== exp_rd) begin
                n_bad++;
                $display("FAIL %s: cycle compare rd_data actual %02h expected %02h",
                         cur_req, rd_data, exp_rd);
            end
        end
    end

    task automatic chk(input logic [7:0] exp, input string req, input string what);
        n_cmp++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s: %s actual %02h expected %02h", req, what, rd_data, exp);
        end
    endtask

    task automatic do_rd(input logic [15:0] a, input string req);
        cur_req = req;
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic do_wr(input logic [15:0] a, input logic [7:0] d, input string req);
        cur_req = req;
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic do_load(input int k, input int pkts);
        @(negedge clk); s_load[k] = 1'b1; s_pkts[k*CW +: CW] = CW'(pkts);
        @(negedge clk); s_load = '0;
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(8'h00, "R12", "reset read data");

        // R9 miscellaneous registers
        do_rd(16'h2197, "R9"); chk(8'h80, "R9", "0x2197 reset");
        do_rd(16'h2196, "R9"); chk(8'h10, "R9", "0x2196 const");
        do_wr(16'h2194, 8'hAB, "R9");
        do_rd(16'h2194, "R9"); chk(8'h0B, "R9", "0x2194 4-bit");
        do_wr(16'h2197, 8'h3C, "R9");
        do_rd(16'h2197, "R9"); chk(8'h3C, "R9", "0x2197 write");
        do_rd(16'h2198, "R9"); chk(8'h00, "R9", "0x2198 zero");

        // R1 channel registers
        do_wr(16'h2188, 8'h34, "R1");
        do_wr(16'h2189, 8'hC5, "R1");
        do_rd(16'h2189, "R1"); chk(8'h05, "R1", "channel high masked");
        do_rd(16'h2188, "R1"); chk(8'h34, "R1", "channel low");

        // R2 disabled latches
        do_rd(16'h218A, "R2"); chk(8'h00, "R2", "count with latches off");
        do_rd(16'h218B, "R2"); chk(8'h00, "R2", "prefix disabled");
        do_wr(16'h218B, 8'h01, "R2");
        do_rd(16'h218A, "R2"); chk(8'h00, "R2", "count with one latch on");
        do_wr(16'h218C, 8'h05, "R2");

        // R3 count
        do_rd(16'h218A, "R3"); chk(8'h00, "R3", "count before load");
        do_load(0, 200);
        do_rd(16'h218A, "R3"); chk(8'h7F, "R3", "count saturated");

        // R4 prefix flags
        do_rd(16'h218B, "R4"); chk(8'h10, "R4", "first packet");
        do_rd(16'h218B, "R4"); chk(8'h00, "R4", "middle packet");
        do_load(0, 2);
        do_rd(16'h218A, "R3"); chk(8'h02, "R3", "small count");
        do_rd(16'h218B, "R4"); chk(8'h10, "R4", "first of two");
        do_rd(16'h218B, "R4"); chk(8'h80, "R4", "last of two");
        do_rd(16'h218A, "R3"); chk(8'h00, "R3", "count empty");

        // R5 status
        do_rd(16'h218D, "R5"); chk(8'h90, "R5", "status accumulated");
        do_rd(16'h218D, "R5"); chk(8'h00, "R5", "status cleared");

        // R6 payload bytes
        bq0.push_back(8'h11); bq0.push_back(8'h22); bq0.push_back(8'h33);
        repeat (2) @(negedge clk);
        do_rd(16'h218C, "R6"); chk(8'h11, "R6", "byte 0");
        do_rd(16'h218C, "R6"); chk(8'h22, "R6", "byte 1");
        do_rd(16'h218C, "R6"); chk(8'h33, "R6", "byte 2");
        do_rd(16'h218C, "R6"); chk(8'hFF, "R6", "exhausted");

        // R12 hold
        repeat (4) @(negedge clk);
        chk(8'hFF, "R12", "read data holds");

        // R11 second stream
        do_wr(16'h218E, 8'h01, "R11");
        do_wr(16'h2191, 8'h01, "R11");
        do_wr(16'h2192, 8'h01, "R11");
        do_load(1, 1);
        do_rd(16'h2191, "R11"); chk(8'h90, "R4", "single packet first+last");
        do_rd(16'h218D, "R11"); chk(8'h00, "R11", "stream 0 status untouched");
        do_rd(16'h2188, "R11"); chk(8'h34, "R11", "stream 0 channel untouched");
        do_rd(16'h2193, "R11"); chk(8'h90, "R11", "stream 1 status");

        // R2 disable again
        do_wr(16'h218B, 8'h00, "R2");
        do_rd(16'h218B, "R2"); chk(8'h00, "R2", "prefix disabled again");
        do_rd(16'h218A, "R2"); chk(8'h00, "R2", "count after disable");

        // R7 / R8 clock channel on stream 1
        do_wr(16'h218E, 8'h00, "R7");
        do_wr(16'h218F, 8'h00, "R7");
        do_rd(16'h2190, "R7"); chk(8'h01, "R7", "count on channel zero");
        do_rd(16'h2191, "R7"); chk(8'h90, "R7", "prefix on channel zero");
        time_in = 64'h07E9_0C1F_0517_3B2A;
        do_wr(16'h2192, 8'h01, "R8");
        time_in = 64'h0;
        for (int i = 0; i < 23; i++) begin
            do_rd(16'h2192, "R7");
            if (i == 4)  chk(8'h10, "R7", "record byte 4");
            if (i == 5)  chk(8'h01, "R7", "record byte 5");
            if (i == 10) chk(8'h2A, "R8", "seconds captured at restart");
            if (i == 12) chk(8'h17, "R7", "hours");
            if (i == 17) chk(8'h07, "R7", "year high");
            if (i == 22) chk(8'h00, "R7", "record byte 22");
        end
        do_rd(16'h2192, "R7"); chk(8'h00, "R7", "wrapped byte 0");
        time_in = 64'h0000_0000_0000_0055;
        do_wr(16'h2192, 8'h01, "R8");
        for (int i = 0; i < 11; i++) do_rd(16'h2192, "R8");
        chk(8'h55, "R8", "new seconds after restart");

        // R10 open bus and ignored writes
        open_bus = 8'hC3;
        do_rd(16'h2000, "R10"); chk(8'hC3, "R10", "below window");
        do_rd(16'h219A, "R10"); chk(8'hC3, "R10", "above window");
        do_wr(16'h2196, 8'h00, "R10");
        do_rd(16'h2196, "R10"); chk(8'h10, "R10", "0x2196 write ignored");
        do_wr(16'h2193, 8'hFF, "R10");
        do_rd(16'h2193, "R10"); chk(8'h90, "R10", "status write ignored");
        do_wr(16'h2195, 8'hFF, "R10");
        do_rd(16'h2195, "R10"); chk(8'h00, "R10", "0x2195 write ignored");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule